// File: doc/BRIEF.md
# Write-Through Data Cache with Cacheable Window

This block sits between a processor's load/store unit and three external paths: a write link, a line-fill link and an uncached bypass bus. It holds a direct-mapped array of lines. Caching applies only when a software enable is set and the access address lies inside a programmable inclusive window. Every cacheable store is sent out on the write link with byte, halfword or word size. If the addressed line is present, the same bytes are also patched in the cached copy. A store that misses never brings its line in.

Loads that hit finish in the cycle they are presented. Loads that miss fetch the whole line over the fill link. The requester stalls until the last beat arrives, and the data is then returned from the freshly filled line. Accesses outside the window, or any access made while the enable is low, go over the bypass bus and leave the array alone. The requester holds its request steady until `req_done` pulses for one cycle. Misaligned or reserved-size requests complete at once with an error flag and start no access.

Top module: `wt_dcache`

## Requirements
- R1: A store with `cache_en`=1 and `win_lo` <= address <= `win_hi` issues exactly one write-link transfer and no fill. `wr_addr` is the word-aligned address. Sizes are encoded 0=byte, 1=halfword, 2=word, and lanes are big-endian, so `wr_be[3]` covers bits 31:24 and byte offset 0. A byte store uses `wr_be` = 4'b1000 >> offset with the byte copied into all four lanes. A halfword uses 4'b1100 at offset 0 or 4'b0011 at offset 2, with the halfword copied into both halves. A word uses 4'b1111. `req_done` pulses in the cycle `wr_ready` completes the handshake.
- R2: A store whose line is cached changes only the enabled bytes of the cached word, and it does so in the cycle the write is accepted. A later load hit returns the merged value.
- R3: A store whose line is absent does not fetch or allocate the line. The next load to that line misses.
- R4: A cacheable load that hits completes in the cycle it is presented and makes no fill, write or bypass access. `req_rdata` holds the addressed byte or halfword, taken from its big-endian lane and zero-extended, or the whole word.
- R5: A cacheable load that misses raises exactly one fill request with the line-aligned address. It accepts LINE_WORDS beats in ascending word order and does not complete until the line is complete. It then returns the correct data.
- R6: With `cache_en`=0, or with the address outside the window, a request uses the bypass bus. This uses the same byte enables and lane data as R1, and a load extracts its result as in R4. It makes no write-link or fill access and completes on `byp_ready`.
- R7: A halfword at an odd address, a word at an offset other than 0, or size code 3 gives `req_done` and `req_err` in the same cycle. No external access is made.
- R8: After reset every line is invalid, so the first cacheable load misses, and no request output is active while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cache_en | input | 1 | Software cache enable |
| win_lo | input | ADDR_W | Lowest cacheable byte address |
| win_hi | input | ADDR_W | Highest cacheable byte address |
| req_valid | input | 1 | Request present, held until done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| req_done | output | 1 | Request complete this cycle |
| req_err | output | 1 | Misaligned or reserved size |
| req_rdata | output | 32 | Load result, zero-extended |
| wr_valid | output | 1 | Write-link request |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_be | output | 4 | Write byte enables |
| wr_data | output | 32 | Lane-placed write data |
| wr_ready | input | 1 | Write accepted |
| fill_req_valid | output | 1 | Line fill request |
| fill_req_addr | output | ADDR_W | Line-aligned fill address |
| fill_req_ready | input | 1 | Fill request accepted |
| fill_data_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat word |
| byp_valid | output | 1 | Bypass bus request |
| byp_write | output | 1 | Bypass store |
| byp_addr | output | ADDR_W | Word-aligned bypass address |
| byp_be | output | 4 | Bypass byte enables |
| byp_wdata | output | 32 | Bypass lane-placed data |
| byp_ready | input | 1 | Bypass transfer done |
| byp_rdata | input | 32 | Bypass read word |

## Verification
The bench goes after the paths where a write-through cache quietly goes stale or over-fetches. A store hit that skips the array patch would make the following hit return the old word. A store miss that allocates would make the next load to that line skip its fill. A lane decoder with the endianness reversed would put bytes in the wrong lane and return the wrong byte. The window edges, the disable path and the evict-on-conflict case are driven by directed accesses. A long random mix on a four-line configuration then checks every load value against a backing-memory model. It also checks every access count against a hit/miss model kept in the bench. Misaligned requests are checked to finish at once with no traffic, since an unguarded decoder would leak a partial write.

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_done,
  output logic              req_err,
  output logic [31:0]       req_rdata,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [3:0]        wr_be,
  output logic [31:0]       wr_data,
  input  logic              wr_ready,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_req_ready,
  input  logic              fill_data_valid,
  input  logic [31:0]       fill_data,
  output logic              byp_valid,
  output logic              byp_write,
  output logic [ADDR_W-1:0] byp_addr,
  output logic [3:0]        byp_be,
  output logic [31:0]       byp_wdata,
  input  logic              byp_ready,
  input  logic [31:0]       byp_rdata
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - 2 - WSEL_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FREQ, S_FILL} st_t;
  st_t state;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q;
  logic [31:0]       data_q [LINES*LINE_WORDS];
  logic [LINE_W-1:0] miss_line;
  logic [WSEL_W-1:0] beat;

  wire [TAG_W-1:0]  a_tag  = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0]  a_idx  = req_addr[2+WSEL_W +: IDX_W];
  wire [WSEL_W-1:0] a_wsel = req_addr[2 +: WSEL_W];
  wire [1:0]        a_off  = req_addr[1:0];
  wire [IDX_W-1:0]  m_idx  = miss_line[IDX_W-1:0];
  wire [TAG_W-1:0]  m_tag  = miss_line[LINE_W-1 -: TAG_W];

  wire misal = (req_size == 2'd3) || (req_size == 2'd2 && a_off != 2'd0) ||
               (req_size == 2'd1 && a_off[0]);
  wire cacheable = cache_en && req_addr >= win_lo && req_addr <= win_hi;
  wire hit       = vld_q[a_idx] && tag_q[a_idx] == a_tag;
  wire idle_req  = state == S_IDLE && req_valid;
  wire go        = idle_req && !misal;
  wire ld_hit    = go && cacheable && !req_write && hit;
  wire ld_miss   = go && cacheable && !req_write && !hit;

  logic [3:0]  lane_be;
  logic [31:0] lane_wd, rd_mask;
  logic [4:0]  rd_shift;

  always_comb begin
    case (req_size)
      2'd0: begin
        lane_be  = 4'b1000 >> a_off;
        lane_wd  = {4{req_wdata[7:0]}};
        rd_shift = 5'((3 - int'(a_off)) * 8);
        rd_mask  = 32'h0000_00ff;
      end
      2'd1: begin
        lane_be  = a_off[1] ? 4'b0011 : 4'b1100;
        lane_wd  = {2{req_wdata[15:0]}};
        rd_shift = a_off[1] ? 5'd0 : 5'd16;
        rd_mask  = 32'h0000_ffff;
      end
      default: begin
        lane_be  = 4'b1111;
        lane_wd  = req_wdata;
        rd_shift = 5'd0;
        rd_mask  = 32'hffff_ffff;
      end
    endcase
  end

  wire [ADDR_W-1:0] word_addr = {req_addr[ADDR_W-1:2], 2'b00};
  wire [31:0]       src_word  = byp_valid ? byp_rdata : data_q[{a_idx, a_wsel}];

  assign wr_valid  = go && cacheable && req_write;
  assign wr_addr   = word_addr;
  assign wr_be     = lane_be;
  assign wr_data   = lane_wd;
  assign byp_valid = go && !cacheable;
  assign byp_write = req_write;
  assign byp_addr  = word_addr;
  assign byp_be    = lane_be;
  assign byp_wdata = lane_wd;
  assign fill_req_valid = state == S_FREQ;
  assign fill_req_addr  = {miss_line, {(WSEL_W+2){1'b0}}};

  assign req_err   = idle_req && misal;
  assign req_done  = req_err || ld_hit || (wr_valid && wr_ready) || (byp_valid && byp_ready);
  assign req_rdata = (src_word >> rd_shift) & rd_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld_q     <= '0;
      miss_line <= '0;
      beat      <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else begin
      case (state)
        S_IDLE: if (ld_miss) begin
          miss_line <= req_addr[ADDR_W-1 -: LINE_W];
          state     <= S_FREQ;
        end
        S_FREQ: if (fill_req_ready) begin
          vld_q[m_idx] <= 1'b0;
          beat         <= '0;
          state        <= S_FILL;
        end
        S_FILL: if (fill_data_valid) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) begin
            vld_q[m_idx] <= 1'b1;
            tag_q[m_idx] <= m_tag;
            state        <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && fill_data_valid)
      data_q[{m_idx, beat}] <= fill_data;
    else if (wr_valid && wr_ready && hit)
      for (int b = 0; b < 4; b++)
        if (lane_be[b]) data_q[{a_idx, a_wsel}][8*b +: 8] <= lane_wd[8*b +: 8];
  end

  // R7
  misal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_done && !wr_valid && !byp_valid && !fill_req_valid));

  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> !req_done);

  // R5
  fill_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> fill_req_addr[WSEL_W+1:0] == '0);

  // R5
  fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && fill_data_valid && beat == LAST_BEAT) |=> (state == S_IDLE && vld_q[m_idx]));

  // R6
  path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, byp_valid, fill_req_valid}));

  // R1
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && req_size == 2'd0) |-> $countones(wr_be) == 1);
endmodule

// File: tb/wt_dcache_tb.sv
module wt_dcache_tb;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, cache_en = 1;
  logic [AW-1:0] win_lo = 10'h000, win_hi = 10'h1ff;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_done, req_err;
  logic [31:0] req_rdata;
  logic wr_valid; logic [AW-1:0] wr_addr; logic [3:0] wr_be; logic [31:0] wr_data;
  logic wr_ready = 0;
  logic fill_req_valid; logic [AW-1:0] fill_req_addr;
  logic fill_req_ready = 0, fill_data_valid = 0;
  logic [31:0] fill_data = 0;
  logic byp_valid, byp_write; logic [AW-1:0] byp_addr; logic [3:0] byp_be; logic [31:0] byp_wdata;
  logic byp_ready = 0;
  logic [31:0] byp_rdata = 0;

  always #5 clk = ~clk;

  wt_dcache #(.ADDR_W(AW), .LINE_WORDS(4), .LINES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .win_lo(win_lo), .win_hi(win_hi),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_err(req_err), .req_rdata(req_rdata),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .wr_ready(wr_ready),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr), .fill_req_ready(fill_req_ready),
    .fill_data_valid(fill_data_valid), .fill_data(fill_data),
    .byp_valid(byp_valid), .byp_write(byp_write), .byp_addr(byp_addr), .byp_be(byp_be),
    .byp_wdata(byp_wdata), .byp_ready(byp_ready), .byp_rdata(byp_rdata));

  logic [31:0] mem [256];
  int n_wr = 0, n_byp = 0, n_fill = 0, nchk = 0, nerr = 0, beat = 0;
  logic fill_busy = 0;
  logic [AW-1:0] fill_base = 0, last_addr = 0;
  logic [3:0] last_be = 0;
  logic [31:0] last_data = 0;
  logic bvld [4];
  logic [3:0] btag [4];

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 0) return 4'b1000 >> off;
    if (sz == 1) return off[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction
  function automatic logic [31:0] exp_lane(input logic [1:0] sz, input logic [31:0] d);
    if (sz == 0) return {4{d[7:0]}};
    if (sz == 1) return {2{d[15:0]}};
    return d;
  endfunction
  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [AW-1:0] a);
    logic [31:0] w = mem[a[AW-1:2]];
    if (sz == 0) return (w >> (8 * (3 - int'(a[1:0])))) & 32'hff;
    if (sz == 1) return (w >> (8 * (2 - int'(a[1:0])))) & 32'hffff;
    return w;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    wr_ready        = wr_valid && ($urandom % 3 != 0);
    byp_ready       = byp_valid && ($urandom % 2 == 0);
    byp_rdata       = mem[byp_addr[AW-1:2]];
    fill_req_ready  = fill_req_valid && ($urandom % 2 == 0);
    fill_data_valid = fill_busy && ($urandom % 4 != 0);
    fill_data       = mem[8'(fill_base[AW-1:2] + 8'(beat))];
  end

  always @(negedge clk) begin
    if (wr_valid && wr_ready) begin
      n_wr++; last_addr = wr_addr; last_be = wr_be; last_data = wr_data;
      for (int k = 0; k < 4; k++) if (wr_be[k]) mem[wr_addr[AW-1:2]][8*k +: 8] = wr_data[8*k +: 8];
    end
    if (byp_valid && byp_ready) begin
      n_byp++; last_addr = byp_addr; last_be = byp_be; last_data = byp_wdata;
      if (byp_write)
        for (int k = 0; k < 4; k++) if (byp_be[k]) mem[byp_addr[AW-1:2]][8*k +: 8] = byp_wdata[8*k +: 8];
    end
    if (fill_req_valid && fill_req_ready) begin
      n_fill++; fill_busy = 1; fill_base = fill_req_addr; beat = 0;
    end else if (fill_busy && fill_data_valid) begin
      beat++;
      if (beat == 4) fill_busy = 0;
    end
  end

  logic [31:0] rd;
  logic er;
  int c_wr, c_byp, c_fill;

  task automatic access(input logic w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] wd);
    c_wr = n_wr; c_byp = n_byp; c_fill = n_fill;
    @(posedge clk); #1;
    req_valid = 1; req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
    do @(negedge clk); while (!req_done);
    rd = req_rdata; er = req_err;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic expect_counts(input string tag, input int dw, input int db, input int df);
    chk(n_wr - c_wr == dw, {tag, " write count"}, 32'(n_wr - c_wr), 32'(dw));
    chk(n_byp - c_byp == db, {tag, " bypass count"}, 32'(n_byp - c_byp), 32'(db));
    chk(n_fill - c_fill == df, {tag, " fill count"}, 32'(n_fill - c_fill), 32'(df));
  endtask

  task automatic model_op(input logic w, input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] wd);
    logic inwin = cache_en && a >= win_lo && a <= win_hi;
    logic [1:0] ix = a[5:4];
    logic [3:0] tg = a[9:6];
    logic h = bvld[ix] && btag[ix] == tg;
    logic [31:0] e;
    access(w, sz, a, wd);
    chk(!er, "R7 unexpected err", 32'(er), 0);
    if (!inwin) begin
      expect_counts("R6", 0, 1, 0);
      chk(last_be == exp_be(sz, a[1:0]), "R6 bypass be", 32'(last_be), 32'(exp_be(sz, a[1:0])));
      if (!w) begin
        e = exp_rd(sz, a);
        chk(rd == e, "R6 bypass load", rd, e);
      end
    end else if (w) begin
      expect_counts("R1", 1, 0, 0);
      chk(last_be == exp_be(sz, a[1:0]), "R1 write be", 32'(last_be), 32'(exp_be(sz, a[1:0])));
      chk(last_data == exp_lane(sz, wd), "R1 write data", last_data, exp_lane(sz, wd));
      chk(last_addr == {a[AW-1:2], 2'b00}, "R1 write addr", 32'(last_addr), 32'({a[AW-1:2], 2'b00}));
    end else begin
      e = exp_rd(sz, a);
      if (h) expect_counts("R4", 0, 0, 0);
      else begin
        expect_counts("R5", 0, 0, 1);
        bvld[ix] = 1; btag[ix] = tg;
      end
      chk(rd == e, h ? "R4 hit data" : "R5 miss data", rd, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'(i) * 32'h9e37_79b1 ^ 32'h5a5a_0000;
    for (int i = 0; i < 4; i++) begin bvld[i] = 0; btag[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R8 quiet outputs with no request
    chk(!req_done && !wr_valid && !byp_valid && !fill_req_valid, "R8 idle outputs",
        {28'd0, req_done, wr_valid, byp_valid, fill_req_valid}, 0);
    rst_n = 1;
    // R8 first load at tag 0 must miss
    model_op(0, 2, 10'h000, 0);
    chk(n_fill == 1, "R8 first load fills", 32'(n_fill), 1);
    model_op(0, 2, 10'h040, 0);
    model_op(0, 0, 10'h041, 0);
    model_op(0, 1, 10'h042, 0);
    // R2 store hit then hit-load of merged word
    model_op(1, 1, 10'h042, 32'h0000_beef);
    model_op(0, 2, 10'h040, 0);
    chk(rd == {mem[16][31:16], 16'hbeef}, "R2 merged word", rd, {mem[16][31:16], 16'hbeef});
    model_op(1, 0, 10'h047, 32'h0000_00c3);
    model_op(0, 0, 10'h047, 0);
    chk(rd == 32'hc3, "R2 byte lane", rd, 32'hc3);
    // R3 store miss does not allocate
    model_op(1, 0, 10'h083, 32'h0000_005a);
    model_op(0, 2, 10'h080, 0);
    chk(n_fill - c_fill == 1, "R3 line not allocated", 32'(n_fill - c_fill), 1);
    // R7 misaligned and reserved size
    access(0, 1, 10'h041, 0);
    chk(er == 1, "R7 odd halfword", 32'(er), 1); expect_counts("R7", 0, 0, 0);
    access(1, 2, 10'h042, 32'h1234_5678);
    chk(er == 1, "R7 word offset", 32'(er), 1); expect_counts("R7", 0, 0, 0);
    access(1, 3, 10'h040, 0);
    chk(er == 1, "R7 size 3", 32'(er), 1); expect_counts("R7", 0, 0, 0);
    // R6 outside window and window edges
    model_op(0, 2, 10'h300, 0);
    model_op(1, 0, 10'h301, 32'h0000_0077);
    model_op(0, 0, 10'h301, 0);
    model_op(0, 2, 10'h1fc, 0);
    model_op(0, 2, 10'h200, 0);
    // R6 disabled: loads of cached lines still bypass
    cache_en = 0;
    model_op(0, 2, 10'h080, 0);
    model_op(0, 1, 10'h1fe, 0);
    cache_en = 1;
    // R1 R2 R3 R4 R5 R6 random sweep
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] sz = 2'($urandom % 3);
      logic [AW-1:0] a = AW'($urandom);
      a = a & ~AW'((1 << sz) - 1);
      model_op(1'($urandom % 2), sz, a, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule